// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Sync Generator

This block is the timing source of a serial audio port when the port drives the clocks. It divides a reference clock down to a serial bit clock and counts bit clocks to mark frame boundaries with a frame-sync strobe. It also gives a one-cycle tick at the start of every bit period, which a downstream shifter uses as its clock enable.

Software programs three fields, each as the wanted value minus one: the divide ratio, the frame length in bit clocks, and the sync width in bit clocks. For I2S or left-justified framing the sync width is set to half the frame, so the output is a half-frame level. For the DSP framings the width field is zero, which gives a pulse one bit clock wide. The word length and channel count are given too, so the block can refuse a frame that is too short to carry them. Two inputs invert the sync and the bit clock, and an enable starts and parks the generator.

Top module: `audio_clkgen`

## Requirements
- R1: `bit_tick_o` is high for one reference cycle at the start of every bit period, and the bit period is N = `div_m1`+1 reference cycles. With `div_m1` = 0 the tick is high on every cycle.
- R2: Within each bit period the bit-clock level is low for the first floor(N/2) reference cycles and high for the rest. When N = 1 the level is the inverted reference clock, so it is low while the reference clock is high.
- R3: A frame is `period_m1`+1 bit periods long. The sync becomes active together with the tick of the first bit of every frame.
- R4: The sync stays active for bits 0 to `width_m1` of the frame (`width_m1`+1 bits). A half-frame width such as (frame/2 − 1) gives a level for I2S or left-justified framing, and 0 gives a single-bit pulse for DSP framing. A width at or above `period_m1` keeps the sync active for the whole frame.
- R5: `fsync_o` is the active-high sync level XOR `fs_inv`, and `bclk_o` is the bit-clock level XOR `bclk_inv`.
- R6: `cfg_err_o` is high, in the same cycle, whenever `period_m1`+1 < `word_len` × `chan_cnt`. While it is high the generator does not start. A generator that is already running stops at the next frame boundary and parks.
- R7: When `enable` is sampled low, from the next cycle `bit_tick_o` is 0, `fsync_o` equals `fs_inv`, `bclk_o` equals `bclk_inv`, and both counters are back at zero.
- R8: In the cycle after the first clock edge that samples `enable` high with a valid configuration, `bit_tick_o` is 1 and the sync is active.
- R9: Changes to `div_m1`, `period_m1` and `width_m1` while the generator runs take effect only from the first bit of the next frame. The current frame always completes with its old settings.
- R10: During and right after reset the outputs are parked as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request |
| div_m1 | input | DIV_W | Divide ratio minus one |
| period_m1 | input | PER_W | Frame length in bit clocks minus one |
| width_m1 | input | PER_W | Sync width in bit clocks minus one |
| word_len | input | WL_W | Bits per sample word, used for the length check |
| chan_cnt | input | CH_W | Words per frame, used for the length check |
| fs_inv | input | 1 | Invert the frame-sync output |
| bclk_inv | input | 1 | Invert the bit-clock output |
| bclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame-sync strobe |
| bit_tick_o | output | 1 | One-cycle strobe at each bit start |
| cfg_err_o | output | 1 | Frame too short for word length × channels |

## Verification
The tick, bit-clock and sync outputs are decoded from registers. A change of `enable` or of the configuration that is sampled at a rising edge therefore shows on them in the reference cycle after that edge, and a new divide ratio, frame length or width shows only from the first bit of the following frame. `cfg_err_o` is combinational and follows the length inputs in the same cycle. The bench drives inputs 2 ns after each falling edge. It advances a behavioural model on each rising edge and compares all four outputs 1 ns after each falling edge, so every result is read one cycle after the edge that caused it and never at an edge.

// File: rtl/acg_pkg.sv
package acg_pkg;

  typedef enum logic {
    ACG_IDLE = 1'b0,
    ACG_RUN  = 1'b1
  } acg_state_e;

  // frame length (bit clocks) must hold word_len * channels bits
  function automatic logic frame_fits(input logic [31:0] per_m1,
                                      input logic [31:0] wlen,
                                      input logic [31:0] chans);
    return (per_m1 + 32'd1) >= (wlen * chans);
  endfunction

endpackage

// File: rtl/acg_divider.sv
module acg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_lim,
  output logic [DIV_W-1:0] dcnt,
  output logic             bit_start,
  output logic             bit_end,
  output logic             bclk_lvl
);
  localparam int DW1 = DIV_W + 1;

  logic [DW1-1:0] n_half;

  // first cycle index of the high half of a bit period
  assign n_half = DW1'(({1'b0, div_lim} + DW1'(1)) >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dcnt <= '0;
    else if (!run)             dcnt <= '0;
    else if (dcnt == div_lim)  dcnt <= '0;
    else                       dcnt <= dcnt + DIV_W'(1);
  end

  assign bit_start = run && (dcnt == '0);
  assign bit_end   = run && (dcnt == div_lim);
  assign bclk_lvl  = run && ((div_lim == '0) ? ~clk : ({1'b0, dcnt} >= n_half));

endmodule

// File: rtl/acg_framer.sv
module acg_framer #(
  parameter int PER_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             bit_end,
  input  logic [PER_W-1:0] per_lim,
  input  logic [PER_W-1:0] wid_lim,
  output logic [PER_W-1:0] bcnt,
  output logic             frame_end,
  output logic             sync_lvl
);

  assign frame_end = bit_end && (bcnt == per_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bcnt <= '0;
    else if (!run)      bcnt <= '0;
    else if (frame_end) bcnt <= '0;
    else if (bit_end)   bcnt <= bcnt + PER_W'(1);
  end

  assign sync_lvl = run && (bcnt <= wid_lim);

endmodule

// File: rtl/acg_ctrl.sv
module acg_ctrl #(
  parameter int DIV_W = 8,
  parameter int PER_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fits,
  input  logic             frame_end,
  input  logic [DIV_W-1:0] div_m1,
  input  logic [PER_W-1:0] period_m1,
  input  logic [PER_W-1:0] width_m1,
  output logic             run,
  output logic [DIV_W-1:0] div_lim,
  output logic [PER_W-1:0] per_lim,
  output logic [PER_W-1:0] wid_lim
);
  import acg_pkg::*;

  acg_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ACG_IDLE;
      div_lim <= '0;
      per_lim <= '0;
      wid_lim <= '0;
    end else begin
      case (state)
        ACG_IDLE: begin
          div_lim <= div_m1;
          per_lim <= period_m1;
          wid_lim <= width_m1;
          if (enable && fits) state <= ACG_RUN;
        end
        default: begin
          if (!enable) begin
            state <= ACG_IDLE;
          end else if (frame_end) begin
            if (fits) begin
              div_lim <= div_m1;
              per_lim <= period_m1;
              wid_lim <= width_m1;
            end else begin
              state <= ACG_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign run = (state == ACG_RUN);

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int DIV_W = 8,
  parameter int PER_W = 9,
  parameter int WL_W  = 6,
  parameter int CH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_m1,
  input  logic [PER_W-1:0] period_m1,
  input  logic [PER_W-1:0] width_m1,
  input  logic [WL_W-1:0]  word_len,
  input  logic [CH_W-1:0]  chan_cnt,
  input  logic             fs_inv,
  input  logic             bclk_inv,
  output logic             bclk_o,
  output logic             fsync_o,
  output logic             bit_tick_o,
  output logic             cfg_err_o
);

  logic             fits;
  logic             run;
  logic [DIV_W-1:0] div_lim;
  logic [PER_W-1:0] per_lim;
  logic [PER_W-1:0] wid_lim;
  logic [DIV_W-1:0] dcnt;
  logic [PER_W-1:0] bcnt;
  logic             bit_start;
  logic             bit_end;
  logic             frame_end;
  logic             bclk_lvl;
  logic             sync_lvl;

  assign fits      = acg_pkg::frame_fits(32'(period_m1), 32'(word_len), 32'(chan_cnt));
  assign cfg_err_o = !fits;

  acg_ctrl #(.DIV_W(DIV_W), .PER_W(PER_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fits(fits), .frame_end(frame_end),
    .div_m1(div_m1), .period_m1(period_m1), .width_m1(width_m1),
    .run(run), .div_lim(div_lim), .per_lim(per_lim), .wid_lim(wid_lim)
  );

  acg_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .div_lim(div_lim),
    .dcnt(dcnt), .bit_start(bit_start), .bit_end(bit_end), .bclk_lvl(bclk_lvl)
  );

  acg_framer #(.PER_W(PER_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .run(run), .bit_end(bit_end),
    .per_lim(per_lim), .wid_lim(wid_lim),
    .bcnt(bcnt), .frame_end(frame_end), .sync_lvl(sync_lvl)
  );

  assign bit_tick_o = bit_start;
  assign bclk_o     = bclk_lvl ^ bclk_inv;
  assign fsync_o    = sync_lvl ^ fs_inv;

endmodule

// File: rtl/acg_checker.sv
module acg_checker #(
  parameter int DIV_W = 8,
  parameter int PER_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             fits,
  input logic             run,
  input logic             frame_end,
  input logic [DIV_W-1:0] div_lim,
  input logic [PER_W-1:0] per_lim,
  input logic [PER_W-1:0] bcnt,
  input logic             sync_lvl,
  input logic             bit_tick_o,
  input logic             fsync_o,
  input logic             bclk_o,
  input logic             fs_inv,
  input logic             bclk_inv
);

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && enable && bit_tick_o && (div_lim != '0) |=> !bit_tick_o);

  // R1
  tick_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && enable && (div_lim == '0) && !frame_end |=> bit_tick_o);

  // R3
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && enable && frame_end && fits |=> bit_tick_o && (bcnt == '0) && sync_lvl);

  // R7
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !bit_tick_o && (fsync_o == fs_inv) && (bclk_o == bclk_inv));

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !fits |=> !run);

  // R8
  first_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> bit_tick_o && sync_lvl);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && enable && !frame_end |=> $stable(div_lim) && $stable(per_lim));

endmodule

bind audio_clkgen acg_checker #(.DIV_W(DIV_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .fits(fits), .run(run),
  .frame_end(frame_end), .div_lim(div_lim), .per_lim(per_lim), .bcnt(bcnt),
  .sync_lvl(sync_lvl), .bit_tick_o(bit_tick_o), .fsync_o(fsync_o),
  .bclk_o(bclk_o), .fs_inv(fs_inv), .bclk_inv(bclk_inv)
);

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] div_m1 = 8'd3;
  logic [8:0] period_m1 = 9'd15;
  logic [8:0] width_m1 = 9'd7;
  logic [5:0] word_len = 6'd8;
  logic [4:0] chan_cnt = 5'd2;
  logic       fs_inv = 1'b0;
  logic       bclk_inv = 1'b0;
  logic       bclk_o, fsync_o, bit_tick_o, cfg_err_o;

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cyc      = 0;
  string phase    = "R10";
  bit    done     = 1'b0;

  // behavioural reference state
  int m_run = 0, m_pos = 0, m_bit = 0;
  int m_n = 1, m_p = 0, m_w = 0;

  always #10 clk = ~clk;

  audio_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_m1(div_m1),
    .period_m1(period_m1), .width_m1(width_m1), .word_len(word_len),
    .chan_cnt(chan_cnt), .fs_inv(fs_inv), .bclk_inv(bclk_inv),
    .bclk_o(bclk_o), .fsync_o(fsync_o), .bit_tick_o(bit_tick_o),
    .cfg_err_o(cfg_err_o)
  );

  function automatic bit live_ok();
    return (int'(period_m1) + 1) >= (int'(word_len) * int'(chan_cnt));
  endfunction

  task automatic take_cfg();
    m_n = int'(div_m1) + 1;
    m_p = int'(period_m1);
    m_w = int'(width_m1);
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s (%s) t=%0t: got %0b expected %0b", req, phase, $time, act, exp);
    end
  endtask

  // reference model advances on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_pos = 0; m_bit = 0;
    end else if (m_run == 0) begin
      take_cfg();
      m_pos = 0; m_bit = 0;
      if (enable && live_ok()) m_run = 1;
    end else if (!enable) begin
      m_run = 0; m_pos = 0; m_bit = 0;
    end else if (m_pos == m_n - 1) begin
      m_pos = 0;
      if (m_bit == m_p) begin
        m_bit = 0;
        if (live_ok()) take_cfg();
        else m_run = 0;
      end else begin
        m_bit++;
      end
    end else begin
      m_pos++;
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk("R1", bit_tick_o, logic'(m_run != 0 && m_pos == 0));
      chk("R2", bclk_o, logic'((m_run != 0 && (m_n == 1 || m_pos >= m_n / 2)) ^ bclk_inv));
      chk("R3", fsync_o, logic'((m_run != 0 && m_bit <= m_w) ^ fs_inv));
      chk("R6", cfg_err_o, logic'(!live_ok()));
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      n_fails++;
      $display("FAIL watchdog: run hung, got %0d cycles expected under 50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic drive_slot();
    @(negedge clk); #2;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive_slot();
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R10 parked right after reset
    chk("R10", bit_tick_o, 1'b0);
    chk("R10", fsync_o, 1'b0);
    chk("R10", bclk_o, 1'b0);
    #1;

    // I2S-style half-frame level, frame exactly word_len*chan long
    phase = "R4";
    enable = 1'b1;
    @(negedge clk); #1;
    chk("R8", bit_tick_o, 1'b1);
    chk("R8", fsync_o, 1'b1);
    #1;
    idle(200);

    // DSP pulse with divide-by-one, changed mid-frame
    phase = "R1";
    div_m1 = 8'd0; period_m1 = 9'd9; width_m1 = 9'd0;
    word_len = 6'd5; chan_cnt = 5'd2;
    idle(120);

    // inverted outputs, odd ratio, width beyond frame
    phase = "R5";
    fs_inv = 1'b1; bclk_inv = 1'b1;
    div_m1 = 8'd2; period_m1 = 9'd11; width_m1 = 9'd20;
    idle(150);

    // mid-frame change must wait for the boundary
    phase = "R9";
    idle(7);
    div_m1 = 8'd5; period_m1 = 9'd7; width_m1 = 9'd3;
    word_len = 6'd4; chan_cnt = 5'd2;
    idle(200);

    // too-short frame: stops at boundary, then refuses to start
    phase = "R6";
    word_len = 6'd8; chan_cnt = 5'd2;
    @(negedge clk); #1;
    chk("R6", cfg_err_o, 1'b1);
    #1;
    idle(120);
    @(negedge clk); #1;
    chk("R6", bit_tick_o, 1'b0);
    #1;
    enable = 1'b0;
    idle(3);
    enable = 1'b1;
    idle(20);
    @(negedge clk); #1;
    chk("R6", bit_tick_o, 1'b0);
    chk("R6", fsync_o, fs_inv);
    #1;

    // disable mid-frame, then restart
    phase = "R7";
    period_m1 = 9'd15; width_m1 = 9'd7; div_m1 = 8'd1;
    fs_inv = 1'b0;
    idle(45);
    enable = 1'b0;
    @(negedge clk); #1;
    chk("R7", bit_tick_o, 1'b0);
    chk("R7", fsync_o, fs_inv);
    chk("R7", bclk_o, bclk_inv);
    #1;
    idle(5);
    enable = 1'b1;
    @(negedge clk); #1;
    chk("R8", bit_tick_o, 1'b1);
    chk("R8", fsync_o, 1'b1);
    #1;
    idle(80);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule